// File: doc/BRIEF.md
# Level-0 Interrupt and Address-Fault Entry Sequencer

This block carries a small 32-bit core from normal execution into either a level-0 interrupt handler or the handler for a misaligned instruction fetch. While idle it watches a level-sensitive interrupt request and a fetch-address check. An interrupt is taken only when the status register allows it. Once an interrupt is taken, the block waits until the pipeline reports that in-flight instructions have retired. For an address fault it starts at once.

It then saves context on a descending stack. Each cycle it writes one 32-bit word through a simple write port at a pre-decremented address. General registers are fetched through a small read-select port. In a single final cycle it hands back a new status word, a new program counter and the final stack pointer, each with its own write strobe. One cycle later it pulses a completion strobe. The surrounding core owns the status, stack-pointer and program-counter registers and commits these values.

Top module: `exc_entry_seq`

## Requirements
- R1: While idle, a high `irq_req` is ignored if status bit 16 (global mask) or status bit 17 (level-0 mask) is set: no stack write, no status write and `busy` stays low.
- R2: An accepted interrupt holds `busy` high with no stack write until `drain_done` is seen high. Pushing starts on the next cycle.
- R3: Interrupt entry writes eight words on consecutive cycles at `sp_in`-4, -8, … -32. The words are, in order: the registers for read-select codes 0 to 5 (R8, R9, R10, R11, R12, LR), the return PC, and the status word as it was before entry.
- R4: Interrupt entry writes a status word that clears bit 15 and bit 28, sets the 3-bit mode field at bits 24:22 to 010, and sets bit 17. All other bits are unchanged.
- R5: The new PC after interrupt entry is `vec_base` + `vec_off` (zero-extended). The saved return PC is the `resume_pc` value present in the cycle `drain_done` is seen.
- R6: While idle, `fetch_valid` high with `fetch_addr` bit 0 set raises an address fault whatever the mask bits are. The fault pushes the fetch address at `sp_in`-4 and then the pre-entry status word at `sp_in`-8.
- R7: Address-fault entry writes a status word with mode 110, bits 21 and 16 set, bits 15 and 28 cleared, and all other bits unchanged. The new PC is `vec_base` + 0x14.
- R8: In the final cycle `sr_we`, `pc_we` and `sp_we` are high together. `sp_out` equals `sp_in` minus 4 times the number of words pushed.
- R9: `busy` is high from the cycle after acceptance through the final load cycle. `entry_done` is high for exactly one cycle, the cycle after the load cycle, with `busy` low. After reset all strobes and `busy` are low.
- R10: If a fault and an interrupt arrive in the same idle cycle, the fault is taken. The interrupt is then judged again against the updated status word, so after a fault (global mask set) it is not taken.
- R11: Requests are sampled only while idle. An interrupt request that drops before it is accepted leaves no trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Level-0 interrupt request, level-sensitive |
| vec_off | input | VOFF_W | Handler offset from the external interrupt controller |
| vec_base | input | XLEN | Exception vector base |
| fetch_valid | input | 1 | Fetch address below is being issued |
| fetch_addr | input | XLEN | Instruction fetch address |
| drain_done | input | 1 | Pipeline reports in-flight instructions retired |
| resume_pc | input | XLEN | PC of first instruction that did not complete |
| sr_in | input | XLEN | Current status register |
| sp_in | input | XLEN | Current stack pointer |
| sav_sel | output | IDX_W | Register read select, codes 0..5 = R8..R12, LR |
| sav_data | input | XLEN | Selected register value |
| mem_we | output | 1 | Stack write strobe |
| mem_addr | output | XLEN | Stack write address |
| mem_wdata | output | XLEN | Stack write data |
| sr_we | output | 1 | Status register load |
| sr_out | output | XLEN | New status word |
| pc_we | output | 1 | Program counter load |
| pc_out | output | XLEN | Handler address |
| sp_we | output | 1 | Stack pointer load |
| sp_out | output | XLEN | Final stack pointer |
| busy | output | 1 | Entry sequence in progress |
| entry_done | output | 1 | One-cycle completion strobe |

## Verification
The entry path is tried with a lone interrupt and a lone fault, both with clear masks. It is also tried with an interrupt under each mask bit on its own, with a fault and an interrupt together, with a fault under set masks, and with status words that already have R, J and unrelated bits set. Together these separate the mask logic from the priority logic and show which status bits are rewritten and which are kept. A held drain with a return PC that changes during the wait shows the capture point. A request that drops while masked shows that nothing is remembered.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int XLEN       = 32;
    localparam int SR_R       = 15;
    localparam int SR_GM      = 16;
    localparam int SR_I0M     = 17;
    localparam int SR_EM      = 21;
    localparam int SR_MODE_LO = 22;
    localparam int SR_J       = 28;
    localparam logic [2:0] MODE_IRQ0   = 3'b010;
    localparam logic [2:0] MODE_AFAULT = 3'b110;
    localparam int IRQ_WORDS  = 8;
    localparam int FLT_WORDS  = 2;
    localparam int GPR_WORDS  = 6;
    localparam int IDX_W      = $clog2(IRQ_WORDS);

    typedef enum logic [1:0] {K_NONE, K_IRQ0, K_AFAULT} kind_e;
    typedef enum logic [1:0] {ST_IDLE, ST_DRAIN, ST_PUSH, ST_LOAD} state_e;
    typedef enum logic [1:0] {SRC_GPR, SRC_PC, SRC_SR} src_e;

    typedef struct packed {
        kind_e           kind;
        logic [XLEN-1:0] sp;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] sr;
        logic [XLEN-1:0] voff;
    } ctx_t;

    function automatic src_e word_src(kind_e k, logic [IDX_W-1:0] i);
        if (k == K_AFAULT)            return (i == '0) ? SRC_PC : SRC_SR;
        if (int'(i) < GPR_WORDS)      return SRC_GPR;
        if (int'(i) == GPR_WORDS)     return SRC_PC;
        return SRC_SR;
    endfunction

    function automatic logic [IDX_W-1:0] last_idx(kind_e k);
        return (k == K_AFAULT) ? IDX_W'(FLT_WORDS - 1) : IDX_W'(IRQ_WORDS - 1);
    endfunction

    function automatic logic [XLEN-1:0] entry_sr(kind_e k, logic [XLEN-1:0] s);
        logic [XLEN-1:0] r;
        r = s;
        r[SR_R] = 1'b0;
        r[SR_J] = 1'b0;
        if (k == K_AFAULT) begin
            r[SR_MODE_LO +: 3] = MODE_AFAULT;
            r[SR_EM] = 1'b1;
            r[SR_GM] = 1'b1;
        end else begin
            r[SR_MODE_LO +: 3] = MODE_IRQ0;
            r[SR_I0M] = 1'b1;
        end
        return r;
    endfunction
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int VOFF_W     = 16,
    parameter int ALIGN_BITS = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    irq_req,
    input  logic [VOFF_W-1:0]       vec_off,
    input  logic                    fetch_valid,
    input  logic [XLEN-1:0]         fetch_addr,
    input  logic                    drain_done,
    input  logic [XLEN-1:0]         resume_pc,
    input  logic [XLEN-1:0]         sr_in,
    input  logic [XLEN-1:0]         sp_in,
    output state_e                  state,
    output ctx_t                    ctx,
    output logic [IDX_W-1:0]        idx,
    output logic                    entry_done
);
    logic fault_now;
    logic irq_ok;

    assign fault_now = fetch_valid && (|fetch_addr[ALIGN_BITS-1:0]);
    assign irq_ok    = irq_req && !sr_in[SR_GM] && !sr_in[SR_I0M];

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            ctx        <= '0;
            idx        <= '0;
            entry_done <= 1'b0;
        end else begin
            entry_done <= (state == ST_LOAD);
            unique case (state)
                ST_IDLE: begin
                    idx <= '0;
                    if (fault_now) begin
                        ctx.kind <= K_AFAULT;
                        ctx.pc   <= fetch_addr;
                        ctx.sp   <= sp_in;
                        ctx.sr   <= sr_in;
                        state    <= ST_PUSH;
                    end else if (irq_ok) begin
                        ctx.kind <= K_IRQ0;
                        ctx.voff <= XLEN'(vec_off);
                        state    <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (drain_done) begin
                        ctx.pc <= resume_pc;
                        ctx.sp <= sp_in;
                        ctx.sr <= sr_in;
                        idx    <= '0;
                        state  <= ST_PUSH;
                    end
                end
                ST_PUSH: begin
                    if (idx == last_idx(ctx.kind)) state <= ST_LOAD;
                    else                           idx   <= idx + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: a masked request leaves the sequencer idle
    assert_masked_irq_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && irq_req && !fault_now && (sr_in[SR_GM] || sr_in[SR_I0M]))
        |=> state == ST_IDLE);
    // R2: no pushing before the pipeline drains
    assert_drain_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN && !drain_done) |=> state == ST_DRAIN);
    // R10: fault wins a tie
    assert_fault_first_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && fault_now) |=> (state == ST_PUSH && ctx.kind == K_AFAULT));
    // R9: completion strobe is a single cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        entry_done |=> !entry_done);
    // R3: the word index never passes the list end
    assert_idx_bound_R3: assert property (@(posedge clk) disable iff (rst)
        state == ST_PUSH |-> idx <= last_idx(ctx.kind));
endmodule

// File: rtl/exc_entry_push.sv
module exc_entry_push
    import exc_entry_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             push_en,
    input  logic [IDX_W-1:0] idx,
    input  kind_e            kind,
    input  logic [XLEN-1:0]  sp_base,
    input  logic [XLEN-1:0]  pc_save,
    input  logic [XLEN-1:0]  sr_save,
    input  logic [XLEN-1:0]  sav_data,
    output logic [IDX_W-1:0] sav_sel,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata
);
    src_e src;

    assign sav_sel  = idx;
    assign mem_we   = push_en;
    assign src      = word_src(kind, idx);
    assign mem_addr = sp_base - ((XLEN'(idx) + XLEN'(1)) << 2);

    always_comb begin
        unique case (src)
            SRC_GPR: mem_wdata = sav_data;
            SRC_PC:  mem_wdata = pc_save;
            default: mem_wdata = sr_save;
        endcase
    end

    // R3: stack writes walk downward one word per cycle
    assert_descend_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) - XLEN'(4));
    // R3: the first write lands just below the captured pointer
    assert_first_slot_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |-> mem_addr == sp_base - XLEN'(4));
endmodule

// File: rtl/exc_entry_load.sv
module exc_entry_load
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] FAULT_OFS = 32'h14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_en,
    input  kind_e           kind,
    input  logic [XLEN-1:0] sp_base,
    input  logic [XLEN-1:0] sr_save,
    input  logic [XLEN-1:0] voff,
    input  logic [XLEN-1:0] vec_base,
    output logic            sr_we,
    output logic [XLEN-1:0] sr_out,
    output logic            pc_we,
    output logic [XLEN-1:0] pc_out,
    output logic            sp_we,
    output logic [XLEN-1:0] sp_out
);
    localparam logic [XLEN-1:0] TOUCHED =
        (XLEN'(1) << SR_R) | (XLEN'(1) << SR_J) | (XLEN'(7) << SR_MODE_LO) |
        (XLEN'(1) << SR_I0M) | (XLEN'(1) << SR_EM) | (XLEN'(1) << SR_GM);

    assign sr_we  = load_en;
    assign pc_we  = load_en;
    assign sp_we  = load_en;
    assign sr_out = entry_sr(kind, sr_save);
    assign pc_out = vec_base + ((kind == K_AFAULT) ? FAULT_OFS : voff);
    assign sp_out = sp_base - ((XLEN'(last_idx(kind)) + XLEN'(1)) << 2);

    // R4: bits outside the rewritten fields pass through untouched
    assert_keep_bits_R4: assert property (@(posedge clk) disable iff (rst)
        sr_we |-> ((sr_out & ~TOUCHED) == (sr_save & ~TOUCHED)));
    // R4: interrupt entry blocks further level-0 requests
    assert_irq_mask_R4: assert property (@(posedge clk) disable iff (rst)
        (sr_we && kind == K_IRQ0) |-> (sr_out[SR_I0M] && !sr_out[SR_R] && !sr_out[SR_J]));
    // R7: fault entry masks everything
    assert_fault_mask_R7: assert property (@(posedge clk) disable iff (rst)
        (sr_we && kind == K_AFAULT) |-> (sr_out[SR_GM] && sr_out[SR_EM]));
    // R8: all three loads commit together
    assert_joint_load_R8: assert property (@(posedge clk) disable iff (rst)
        sr_we |-> (pc_we && sp_we));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int              VOFF_W     = 16,
    parameter int              ALIGN_BITS = 1,
    parameter logic [XLEN-1:0] FAULT_OFS  = 32'h14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_req,
    input  logic [VOFF_W-1:0] vec_off,
    input  logic [XLEN-1:0]   vec_base,
    input  logic              fetch_valid,
    input  logic [XLEN-1:0]   fetch_addr,
    input  logic              drain_done,
    input  logic [XLEN-1:0]   resume_pc,
    input  logic [XLEN-1:0]   sr_in,
    input  logic [XLEN-1:0]   sp_in,
    output logic [IDX_W-1:0]  sav_sel,
    input  logic [XLEN-1:0]   sav_data,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic              sr_we,
    output logic [XLEN-1:0]   sr_out,
    output logic              pc_we,
    output logic [XLEN-1:0]   pc_out,
    output logic              sp_we,
    output logic [XLEN-1:0]   sp_out,
    output logic              busy,
    output logic              entry_done
);
    state_e           state;
    ctx_t             ctx;
    logic [IDX_W-1:0] idx;

    exc_entry_ctrl #(.VOFF_W(VOFF_W), .ALIGN_BITS(ALIGN_BITS)) u_ctrl (
        .clk(clk), .rst(rst), .irq_req(irq_req), .vec_off(vec_off),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .drain_done(drain_done), .resume_pc(resume_pc),
        .sr_in(sr_in), .sp_in(sp_in),
        .state(state), .ctx(ctx), .idx(idx), .entry_done(entry_done)
    );

    exc_entry_push u_push (
        .clk(clk), .rst(rst), .push_en(state == ST_PUSH), .idx(idx),
        .kind(ctx.kind), .sp_base(ctx.sp), .pc_save(ctx.pc), .sr_save(ctx.sr),
        .sav_data(sav_data), .sav_sel(sav_sel),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    exc_entry_load #(.FAULT_OFS(FAULT_OFS)) u_load (
        .clk(clk), .rst(rst), .load_en(state == ST_LOAD), .kind(ctx.kind),
        .sp_base(ctx.sp), .sr_save(ctx.sr), .voff(ctx.voff), .vec_base(vec_base),
        .sr_we(sr_we), .sr_out(sr_out), .pc_we(pc_we), .pc_out(pc_out),
        .sp_we(sp_we), .sp_out(sp_out)
    );

    assign busy = (state != ST_IDLE);

    // R9: completion is reported only once the sequence has left the busy states
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        entry_done |-> !busy);
    // R9: stack writes happen only while busy
    assert_write_busy_R9: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);
endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
    localparam int B_GM = 16, B_I0M = 17, B_EM = 21, B_R = 15, B_J = 28, B_MODE = 22;
    localparam logic [31:0] VBASE = 32'h8000_0000;
    localparam logic [15:0] VOFF  = 16'h0240;
    localparam logic [31:0] SP0   = 32'h2000_1000;
    localparam logic [31:0] FADDR = 32'h0000_4A13;
    localparam logic [31:0] RPC   = 32'h0000_3C40;

    typedef struct packed {
        logic        irq;
        logic        flt;
        logic [31:0] sr0;
        logic [1:0]  expk; // 0 none, 1 interrupt, 2 fault
    } vec_t;

    localparam vec_t VT [7] = '{
        '{1'b1, 1'b0, 32'h0000_0000, 2'd1},
        '{1'b1, 1'b0, 32'h0001_0000, 2'd0},
        '{1'b1, 1'b0, 32'h0002_0000, 2'd0},
        '{1'b0, 1'b1, 32'h0000_0000, 2'd2},
        '{1'b1, 1'b1, 32'h0000_0000, 2'd2},
        '{1'b0, 1'b1, 32'h1003_8000, 2'd2},
        '{1'b1, 1'b0, 32'h1020_80FF, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_req = 1'b0, fetch_valid = 1'b0, drain_done = 1'b0;
    logic [31:0] fetch_addr = FADDR, resume_pc = RPC;
    logic [31:0] sr_q = '0, sp_q = SP0;
    logic [2:0]  sav_sel;
    logic [31:0] sav_data;
    logic        mem_we, sr_we, pc_we, sp_we, busy, entry_done;
    logic [31:0] mem_addr, mem_wdata, sr_out, pc_out, sp_out;
    logic [31:0] gpr [8];

    int checks = 0, fails = 0;
    int nw, ndone, nbusy;
    logic [31:0] wa [16];
    logic [31:0] wd [16];
    logic [31:0] got_sr, got_pc, got_sp;
    logic        busy_at_done, joint_ok;

    always #4 clk = ~clk;

    assign sav_data = gpr[sav_sel];

    exc_entry_seq dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .vec_off(VOFF), .vec_base(VBASE),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .drain_done(drain_done),
        .resume_pc(resume_pc), .sr_in(sr_q), .sp_in(sp_q),
        .sav_sel(sav_sel), .sav_data(sav_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .sr_we(sr_we), .sr_out(sr_out), .pc_we(pc_we), .pc_out(pc_out),
        .sp_we(sp_we), .sp_out(sp_out), .busy(busy), .entry_done(entry_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_sr(input int k, input logic [31:0] s);
        logic [31:0] r;
        r = s;
        r[B_R] = 1'b0;
        r[B_J] = 1'b0;
        if (k == 2) begin
            r[B_MODE +: 3] = 3'b110; r[B_EM] = 1'b1; r[B_GM] = 1'b1;
        end else begin
            r[B_MODE +: 3] = 3'b010; r[B_I0M] = 1'b1;
        end
        return r;
    endfunction

    // one cycle: sample at the falling edge, model the core registers
    task automatic cyc();
        @(negedge clk);
        if (mem_we && nw < 16) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; nw++; end
        if (sr_we) begin
            sr_q = sr_out; got_sr = sr_out;
            joint_ok = joint_ok && pc_we && sp_we;
        end
        if (pc_we) got_pc = pc_out;
        if (sp_we) begin sp_q = sp_out; got_sp = sp_out; end
        if (entry_done) begin ndone++; busy_at_done = busy; end
        if (busy) nbusy++;
    endtask

    task automatic clear_log();
        nw = 0; ndone = 0; nbusy = 0;
        got_sr = '0; got_pc = '0; got_sp = '0;
        busy_at_done = 1'b1; joint_ok = 1'b1;
    endtask

    task automatic do_reset();
        rst = 1'b1; irq_req = 1'b0; fetch_valid = 1'b0; drain_done = 1'b0;
        cyc(); cyc();
        rst = 1'b0;
    endtask

    task automatic check_entry(input int k, input logic [31:0] s0, input logic [31:0] rpc, input string tag);
        int n;
        logic [31:0] ew;
        n = (k == 2) ? 2 : 8;
        chk(nw == n, {tag, " R3/R6 word count"}, 32'(nw), 32'(n));
        for (int i = 0; i < n && i < nw; i++) begin
            if (k == 2) ew = (i == 0) ? FADDR : s0;
            else        ew = (i < 6) ? gpr[i] : ((i == 6) ? rpc : s0);
            chk(wa[i] == SP0 - 32'(4 * (i + 1)), {tag, " R3 address"}, wa[i], SP0 - 32'(4 * (i + 1)));
            chk(wd[i] == ew, {tag, (k == 2) ? " R6 data" : " R3 data"}, wd[i], ew);
        end
        chk(got_sr == exp_sr(k, s0), {tag, (k == 2) ? " R7 status" : " R4 status"}, got_sr, exp_sr(k, s0));
        chk(got_pc == ((k == 2) ? VBASE + 32'h14 : VBASE + 32'(VOFF)),
            {tag, (k == 2) ? " R7 pc" : " R5 pc"}, got_pc,
            (k == 2) ? VBASE + 32'h14 : VBASE + 32'(VOFF));
        chk(got_sp == SP0 - 32'(4 * n) && joint_ok, {tag, " R8 sp"}, got_sp, SP0 - 32'(4 * n));
        chk(ndone == 1 && !busy_at_done, {tag, " R9 done pulse"}, 32'(ndone), 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) gpr[i] = 32'h1111_0000 + 32'(i) * 32'h0101;
        clear_log();

        // reset state (R9)
        rst = 1'b1;
        cyc(); cyc();
        chk(!busy && !mem_we && !entry_done && !sr_we && !pc_we && !sp_we, "R9 reset outputs",
            {26'b0, busy, mem_we, entry_done, sr_we, pc_we, sp_we}, 32'd0);

        // vector walk
        for (int v = 0; v < 7; v++) begin
            int post_busy;
            string tag;
            tag = $sformatf("vec%0d", v);
            do_reset();
            sr_q = VT[v].sr0; sp_q = SP0; resume_pc = RPC;
            clear_log();
            irq_req = VT[v].irq; fetch_valid = VT[v].flt;
            cyc();
            fetch_valid = 1'b0;
            for (int c = 0; c < 40 && ndone == 0; c++) begin
                if (c == 3) drain_done = 1'b1;
                cyc();
            end
            // irq stays high: R10/R2 re-evaluation against the updated status
            post_busy = 0;
            for (int c = 0; c < 6; c++) begin
                cyc();
                if (busy || mem_we) post_busy++;
            end
            irq_req = 1'b0; drain_done = 1'b0;
            if (VT[v].expk == 2'd0) begin
                chk(nw == 0 && ndone == 0 && nbusy == 0, {tag, " R1 masked request ignored"},
                    32'(nw + nbusy), 32'd0);
            end else begin
                check_entry(int'(VT[v].expk), VT[v].sr0, RPC, tag);
                chk(post_busy == 0, {tag, " R10 no re-entry after status update"}, 32'(post_busy), 32'd0);
            end
        end

        // held drain and return-PC capture point (R2, R5)
        do_reset();
        sr_q = '0; sp_q = SP0; resume_pc = RPC;
        clear_log();
        irq_req = 1'b1;
        cyc();
        for (int c = 0; c < 6; c++) cyc();
        chk(busy && nw == 0, "R2 busy with no writes while draining", 32'(nw), 32'd0);
        resume_pc = 32'h0000_5550;
        drain_done = 1'b1;
        for (int c = 0; c < 40 && ndone == 0; c++) cyc();
        irq_req = 1'b0; drain_done = 1'b0;
        chk(nw == 8 && wd[6] == 32'h0000_5550, "R5 return pc captured at drain", wd[6], 32'h0000_5550);
        check_entry(1, 32'h0, 32'h0000_5550, "drain");

        // dropped request is not remembered (R11)
        do_reset();
        sr_q = 32'h0001_0000; sp_q = SP0;
        clear_log();
        irq_req = 1'b1;
        cyc(); cyc();
        irq_req = 1'b0;
        cyc();
        sr_q = '0;
        drain_done = 1'b1;
        for (int c = 0; c < 8; c++) cyc();
        drain_done = 1'b0;
        chk(nbusy == 0 && nw == 0 && ndone == 0, "R11 dropped request leaves no entry",
            32'(nbusy + nw), 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #400000;
        checks++; fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule